// File: doc/BRIEF.md
# Nibble-Pair Lookup ALU with Result and Carry Latches

This block is the arithmetic heart of a small 4-bit calculator datapath. Each operation takes its two 4-bit operands from the low and high halves of one register pair, and a 6-bit operation code taken from the instruction selects the function. The computed byte does not go back to the register. It is captured in an 8-bit result latch, which the rest of the datapath can later place on its shared bus. A one-bit carry latch can copy bit 4 of the result latch, and that bit becomes the carry or borrow input of the next chained operation.

The function set covers binary and decimal (BCD) nibble addition and subtraction, with and without carry. It also has bitwise logic, byte rotates, nibble swap and pass-through, and increment and decrement in two forms: across the whole byte, or on each nibble alone. Decimal increment and decrement work on a two-digit byte. Three compare operations leave a single flag in bit 4, ready for the carry latch. A swap variant also presents the swapped byte on a write-back port, so that the source register can be updated in the same cycle.

Top module: `nib_alu_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, the result latch and the carry latch both clear to 0.
- R2: The result latch loads only on a rising edge with `alu_load` high and holds otherwise. Opcode 0x00 (pass) loads {opnd_hi, opnd_lo}.
- R3: Opcode 0x01 (swap) loads {opnd_lo, opnd_hi}. Opcode 0x02 loads the same byte, and while `alu_load` is high with 0x02 it also drives `wb_en` high with `wb_data` = {opnd_lo, opnd_hi}. In every other case `wb_en` is low.
- R4: Binary add 0x03 (lo+hi) and add-with-carry 0x04 (lo+hi+carry) place the sum in bits [3:0], the carry out in bit 4, and zero in bits [7:5].
- R5: Binary subtract 0x05 (lo−hi) and subtract-with-borrow 0x06 (lo−hi−carry) place the difference mod 16 in bits [3:0], 1 in bit 4 when a borrow occurred, and zero in bits [7:5].
- R6: Opcodes 0x07 (AND), 0x08 (OR) and 0x09 (XOR) combine lo with hi into bits [3:0] and give zero in bits [7:4].
- R7: Opcodes 0x0A and 0x0B rotate the byte {hi, lo} by one bit, to the left and to the right respectively.
- R8: Opcodes 0x0C and 0x0D add 1 to and subtract 1 from the byte {hi, lo} mod 256. Opcodes 0x0E and 0x0F do the same to each nibble alone, mod 16, with nothing passing between the nibbles.
- R9: Decimal add 0x10 (lo+hi) and decimal add-with-carry 0x11 (lo+hi+carry) give a BCD digit in bits [3:0]. A raw sum above 9 is corrected by +6 and sets bit 4. Bits [7:5] are zero.
- R10: Decimal subtract 0x12 (lo−hi) and decimal subtract-with-borrow 0x13 (lo−hi−carry) give a BCD digit in bits [3:0]. On a borrow the digit is corrected by −6 and bit 4 is set. Bits [7:5] are zero.
- R11: Opcodes 0x14 and 0x15 step the two-digit BCD value {hi, lo} up and down by one, wrapping 99→00 and 00→99.
- R12: Compare opcodes 0x16 (lo = hi), 0x17 (lo > hi) and 0x18 (lo ≥ hi), all unsigned, put the flag in bit 4 and zero in every other bit.
- R13: On a rising edge with `flag_load` high, the carry latch takes bit 4 of the result latch as it was before that edge. Otherwise the carry latch holds. It is the carry-in of 0x04, 0x06, 0x11 and 0x13.
- R14: Opcodes 0x19 to 0x3F load 0x00 into the result latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| alu_op | input | 6 | Operation code from the instruction |
| opnd_lo | input | 4 | Low nibble of the selected register pair |
| opnd_hi | input | 4 | High nibble of the selected register pair |
| alu_load | input | 1 | Capture the computed byte into the result latch |
| flag_load | input | 1 | Copy result-latch bit 4 into the carry latch |
| alu_latch | output | 8 | Result latch contents |
| carry_flag | output | 1 | Carry latch contents |
| wb_en | output | 1 | Write-back strobe for the swap-with-write-back operation |
| wb_data | output | 8 | Byte to write back into the register pair |

## Verification
The hardest cases to reach are the carry-consuming operations with a carry-in of 1. A carry of 1 only exists after an earlier operation has produced a 1 in bit 4 of the result latch and a separate `flag_load` cycle has moved it across. The stimulus therefore builds each such case as a short sequence: first an overflowing add (or a compare that comes out true), then a flag-load cycle with the result latch held, then the chained operation. A zero-producing add clears the carry again. The same path checks that the carry latch reads the old latch value and not the byte being computed in that cycle.

// File: rtl/nib_alu_pkg.sv
package nib_alu_pkg;

    localparam int NIB_W  = 4;
    localparam int BYTE_W = 2 * NIB_W;
    localparam int OP_W   = 6;
    localparam int FLAG_B = NIB_W;            // bit of the result the carry latch samples
    localparam int PAD_W  = BYTE_W - NIB_W - 1;
    localparam logic [NIB_W-1:0] BCD_MAX = NIB_W'(9);
    localparam logic [NIB_W-1:0] BCD_ADJ = NIB_W'(6);

    typedef enum logic [OP_W-1:0] {
        OP_PASS   = 6'h00,
        OP_SWAP   = 6'h01,
        OP_SWAPWB = 6'h02,
        OP_ADD    = 6'h03,
        OP_ADC    = 6'h04,
        OP_SUB    = 6'h05,
        OP_SBC    = 6'h06,
        OP_AND    = 6'h07,
        OP_OR     = 6'h08,
        OP_XOR    = 6'h09,
        OP_ROL    = 6'h0A,
        OP_ROR    = 6'h0B,
        OP_INC8   = 6'h0C,
        OP_DEC8   = 6'h0D,
        OP_INC44  = 6'h0E,
        OP_DEC44  = 6'h0F,
        OP_DADD   = 6'h10,
        OP_DADC   = 6'h11,
        OP_DSUB   = 6'h12,
        OP_DSBC   = 6'h13,
        OP_DINC8  = 6'h14,
        OP_DDEC8  = 6'h15,
        OP_CMPEQ  = 6'h16,
        OP_CMPGT  = 6'h17,
        OP_CMPGE  = 6'h18
    } alu_op_e;

    typedef struct packed {
        logic [NIB_W-1:0] hi;
        logic [NIB_W-1:0] lo;
    } nib_pair_t;

    typedef struct packed {
        logic             flag;
        logic [NIB_W-1:0] digit;
    } digit_res_t;

    typedef struct packed {
        logic              hit;
        logic [BYTE_W-1:0] value;
    } unit_out_t;

    // Place a digit and a flag into the low half of a byte, upper bits zero.
    function automatic logic [BYTE_W-1:0] pack_flag(input digit_res_t r);
        return {{PAD_W{1'b0}}, r.flag, r.digit};
    endfunction

    // One BCD digit add with decimal correction.
    function automatic digit_res_t bcd_add(input logic [NIB_W-1:0] a,
                                           input logic [NIB_W-1:0] b,
                                           input logic             ci);
        logic [NIB_W:0] raw;
        logic [NIB_W:0] fixed;
        digit_res_t     r;
        raw   = {1'b0, a} + {1'b0, b} + {{NIB_W{1'b0}}, ci};
        fixed = raw + {1'b0, BCD_ADJ};
        if (raw > {1'b0, BCD_MAX}) begin
            r.flag  = 1'b1;
            r.digit = fixed[NIB_W-1:0];
        end else begin
            r.flag  = 1'b0;
            r.digit = raw[NIB_W-1:0];
        end
        return r;
    endfunction

    // One BCD digit subtract with decimal correction on borrow.
    function automatic digit_res_t bcd_sub(input logic [NIB_W-1:0] a,
                                           input logic [NIB_W-1:0] b,
                                           input logic             bi);
        logic [NIB_W:0] raw;
        digit_res_t     r;
        raw = {1'b0, a} - {1'b0, b} - {{NIB_W{1'b0}}, bi};
        r.flag = raw[NIB_W];
        if (raw[NIB_W]) r.digit = raw[NIB_W-1:0] - BCD_ADJ;
        else            r.digit = raw[NIB_W-1:0];
        return r;
    endfunction

endpackage

// File: rtl/nib_alu_bin.sv
// Binary nibble arithmetic, logic and compares.
module nib_alu_bin
    import nib_alu_pkg::*;
(
    input  alu_op_e   op,
    input  nib_pair_t opnd,
    input  logic      cin,
    output unit_out_t res
);
    logic           use_cin;
    logic [NIB_W:0] sum_w;
    logic [NIB_W:0] dif_w;
    logic [NIB_W:0] cmp_w;
    logic           cmp_zero;
    logic           cmp_borrow;
    digit_res_t     sum_r;
    digit_res_t     dif_r;
    digit_res_t     cmp_r;

    assign use_cin = (op == OP_ADC) || (op == OP_SBC);

    assign sum_w = {1'b0, opnd.lo} + {1'b0, opnd.hi} + {{NIB_W{1'b0}}, use_cin & cin};
    assign dif_w = {1'b0, opnd.lo} - {1'b0, opnd.hi} - {{NIB_W{1'b0}}, use_cin & cin};
    assign cmp_w = {1'b0, opnd.lo} - {1'b0, opnd.hi};

    assign cmp_zero   = (cmp_w[NIB_W-1:0] == '0);
    assign cmp_borrow = cmp_w[NIB_W];

    assign sum_r = '{flag: sum_w[NIB_W], digit: sum_w[NIB_W-1:0]};
    assign dif_r = '{flag: dif_w[NIB_W], digit: dif_w[NIB_W-1:0]};

    always_comb begin
        cmp_r.digit = '0;
        case (op)
            OP_CMPEQ: cmp_r.flag = cmp_zero;
            OP_CMPGT: cmp_r.flag = !cmp_borrow && !cmp_zero;
            default:  cmp_r.flag = !cmp_borrow;
        endcase
    end

    always_comb begin
        res.hit   = 1'b1;
        res.value = '0;
        case (op)
            OP_ADD, OP_ADC: res.value = pack_flag(sum_r);
            OP_SUB, OP_SBC: res.value = pack_flag(dif_r);
            OP_AND:         res.value = {{NIB_W{1'b0}}, opnd.lo & opnd.hi};
            OP_OR:          res.value = {{NIB_W{1'b0}}, opnd.lo | opnd.hi};
            OP_XOR:         res.value = {{NIB_W{1'b0}}, opnd.lo ^ opnd.hi};
            OP_CMPEQ, OP_CMPGT, OP_CMPGE: res.value = pack_flag(cmp_r);
            default:        res.hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/nib_alu_byte.sv
// Byte-wide moves, rotates and increment/decrement in byte or nibble form.
module nib_alu_byte
    import nib_alu_pkg::*;
(
    input  alu_op_e   op,
    input  nib_pair_t opnd,
    output unit_out_t res
);
    localparam int NUM_NIB = BYTE_W / NIB_W;

    logic [BYTE_W-1:0] whole;
    logic [BYTE_W-1:0] swapped;
    logic [BYTE_W-1:0] nib_up;
    logic [BYTE_W-1:0] nib_dn;

    assign whole   = {opnd.hi, opnd.lo};
    assign swapped = {opnd.lo, opnd.hi};

    // Each nibble steps on its own; no carry crosses a nibble boundary.
    for (genvar g = 0; g < NUM_NIB; g++) begin : g_nib
        logic [NIB_W-1:0] cur;
        assign cur = whole[g*NIB_W +: NIB_W];
        assign nib_up[g*NIB_W +: NIB_W] = cur + NIB_W'(1);
        assign nib_dn[g*NIB_W +: NIB_W] = cur - NIB_W'(1);
    end

    always_comb begin
        res.hit   = 1'b1;
        res.value = '0;
        case (op)
            OP_PASS:           res.value = whole;
            OP_SWAP,
            OP_SWAPWB:         res.value = swapped;
            OP_ROL:            res.value = {whole[BYTE_W-2:0], whole[BYTE_W-1]};
            OP_ROR:            res.value = {whole[0], whole[BYTE_W-1:1]};
            OP_INC8:           res.value = whole + BYTE_W'(1);
            OP_DEC8:           res.value = whole - BYTE_W'(1);
            OP_INC44:          res.value = nib_up;
            OP_DEC44:          res.value = nib_dn;
            default:           res.hit   = 1'b0;
        endcase
    end
endmodule

// File: rtl/nib_alu_dec.sv
// Decimal (BCD) digit arithmetic and two-digit step.
module nib_alu_dec
    import nib_alu_pkg::*;
(
    input  alu_op_e   op,
    input  nib_pair_t opnd,
    input  logic      cin,
    output unit_out_t res
);
    logic       use_cin;
    digit_res_t add_r;
    digit_res_t sub_r;
    digit_res_t up_lo;
    digit_res_t up_hi;
    digit_res_t dn_lo;
    digit_res_t dn_hi;

    assign use_cin = (op == OP_DADC) || (op == OP_DSBC);

    assign add_r = bcd_add(opnd.lo, opnd.hi, use_cin & cin);
    assign sub_r = bcd_sub(opnd.lo, opnd.hi, use_cin & cin);

    // Ripple through the two digits; final carry/borrow wraps away.
    assign up_lo = bcd_add(opnd.lo, '0, 1'b1);
    assign up_hi = bcd_add(opnd.hi, '0, up_lo.flag);
    assign dn_lo = bcd_sub(opnd.lo, '0, 1'b1);
    assign dn_hi = bcd_sub(opnd.hi, '0, dn_lo.flag);

    always_comb begin
        res.hit   = 1'b1;
        res.value = '0;
        case (op)
            OP_DADD, OP_DADC: res.value = pack_flag(add_r);
            OP_DSUB, OP_DSBC: res.value = pack_flag(sub_r);
            OP_DINC8:         res.value = {up_hi.digit, up_lo.digit};
            OP_DDEC8:         res.value = {dn_hi.digit, dn_lo.digit};
            default:          res.hit   = 1'b0;
        endcase
    end
endmodule

// File: rtl/nib_alu_top.sv
module nib_alu_top
    import nib_alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [OP_W-1:0]   alu_op,
    input  logic [NIB_W-1:0]  opnd_lo,
    input  logic [NIB_W-1:0]  opnd_hi,
    input  logic              alu_load,
    input  logic              flag_load,
    output logic [BYTE_W-1:0] alu_latch,
    output logic              carry_flag,
    output logic              wb_en,
    output logic [BYTE_W-1:0] wb_data
);
    alu_op_e           op;
    nib_pair_t         pair;
    unit_out_t         bin_o;
    unit_out_t         byte_o;
    unit_out_t         dec_o;
    logic [BYTE_W-1:0] next_val;

    assign op   = alu_op_e'(alu_op);
    assign pair = '{hi: opnd_hi, lo: opnd_lo};

    nib_alu_bin  u_bin  (.op(op), .opnd(pair), .cin(carry_flag), .res(bin_o));
    nib_alu_byte u_byte (.op(op), .opnd(pair), .res(byte_o));
    nib_alu_dec  u_dec  (.op(op), .opnd(pair), .cin(carry_flag), .res(dec_o));

    always_comb begin
        if (bin_o.hit)       next_val = bin_o.value;
        else if (byte_o.hit) next_val = byte_o.value;
        else if (dec_o.hit)  next_val = dec_o.value;
        else                 next_val = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            alu_latch  <= '0;
            carry_flag <= 1'b0;
        end else begin
            if (alu_load)  alu_latch  <= next_val;
            if (flag_load) carry_flag <= alu_latch[FLAG_B];
        end
    end

    assign wb_en   = alu_load && (op == OP_SWAPWB);
    assign wb_data = byte_o.value;
endmodule

// File: rtl/nib_alu_chk.sv
module nib_alu_chk
    import nib_alu_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [OP_W-1:0]   alu_op,
    input logic [NIB_W-1:0]  opnd_lo,
    input logic [NIB_W-1:0]  opnd_hi,
    input logic              alu_load,
    input logic              flag_load,
    input logic [BYTE_W-1:0] alu_latch,
    input logic              carry_flag,
    input logic              wb_en,
    input logic [BYTE_W-1:0] wb_data
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        $past(rst) |-> (alu_latch == '0 && !carry_flag)); // R1

    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !alu_load |=> $stable(alu_latch)); // R2

    AST_PASS_COPIES: assert property (@(posedge clk) disable iff (rst)
        (alu_load && alu_op == OP_PASS) |=> alu_latch == {$past(opnd_hi), $past(opnd_lo)}); // R2

    AST_WB_MATCHES_LATCH: assert property (@(posedge clk) disable iff (rst)
        wb_en |=> alu_latch == $past(wb_data)); // R3

    AST_WB_NEEDS_LOAD: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> alu_load); // R3

    AST_LOGIC_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (alu_load && (alu_op == OP_AND || alu_op == OP_OR || alu_op == OP_XOR))
        |=> alu_latch[BYTE_W-1:NIB_W] == '0); // R6

    AST_CMP_SINGLE_BIT: assert property (@(posedge clk) disable iff (rst)
        (alu_load && (alu_op == OP_CMPEQ || alu_op == OP_CMPGT || alu_op == OP_CMPGE))
        |=> $countones(alu_latch) <= 1 && alu_latch[NIB_W-1:0] == '0); // R12

    AST_CARRY_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        flag_load |=> carry_flag == $past(alu_latch[FLAG_B])); // R13

    AST_CARRY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !flag_load |=> $stable(carry_flag)); // R13

    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (alu_load && alu_op > OP_CMPGE) |=> alu_latch == '0); // R14
endmodule

bind nib_alu_top nib_alu_chk u_chk (.*);

// File: tb/tb_nib_alu_top.sv
module tb_nib_alu_top;
    logic       clk = 1'b0;
    logic       rst;
    logic [5:0] alu_op;
    logic [3:0] opnd_lo;
    logic [3:0] opnd_hi;
    logic       alu_load;
    logic       flag_load;
    logic [7:0] alu_latch;
    logic       carry_flag;
    logic       wb_en;
    logic [7:0] wb_data;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    nib_alu_top dut (
        .clk(clk), .rst(rst), .alu_op(alu_op), .opnd_lo(opnd_lo), .opnd_hi(opnd_hi),
        .alu_load(alu_load), .flag_load(flag_load), .alu_latch(alu_latch),
        .carry_flag(carry_flag), .wb_en(wb_en), .wb_data(wb_data)
    );

    task automatic check(input string req, input string what,
                         input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s %s: got 0x%02h expected 0x%02h", req, what, got, exp);
        end
    endtask

    // Drive one op at a falling edge, load on the next rising edge, sample at the next falling edge.
    task automatic run_op(input logic [5:0] op, input logic [3:0] lo, input logic [3:0] hi);
        @(negedge clk);
        alu_op = op; opnd_lo = lo; opnd_hi = hi; alu_load = 1'b1;
        @(negedge clk);
        alu_load = 1'b0;
    endtask

    task automatic op_check(input string req, input logic [5:0] op,
                            input logic [3:0] lo, input logic [3:0] hi, input logic [7:0] exp);
        run_op(op, lo, hi);
        check(req, $sformatf("op 0x%02h lo %h hi %h", op, lo, hi), alu_latch, exp);
    endtask

    task automatic pulse_flag();
        @(negedge clk);
        flag_load = 1'b1;
        @(negedge clk);
        flag_load = 1'b0;
    endtask

    // Set the carry latch via an add whose bit 4 is the wanted value.
    task automatic set_carry(input logic v);
        if (v) run_op(6'h03, 4'hF, 4'h1);
        else   run_op(6'h03, 4'h1, 4'h1);
        pulse_flag();
        check("R13", "carry after flag load", {7'b0, carry_flag}, {7'b0, v});
    endtask

    task automatic t_reset();
        run_op(6'h00, 4'hA, 4'h5);
        set_carry(1'b1);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R1", "latch after reset", alu_latch, 8'h00);
        check("R1", "carry after reset", {7'b0, carry_flag}, 8'h00);
    endtask

    task automatic t_pass_hold();
        op_check("R2", 6'h00, 4'h3, 4'hC, 8'hC3);
        @(negedge clk); alu_op = 6'h09; opnd_lo = 4'hF; opnd_hi = 4'h0;
        @(negedge clk);
        check("R2", "latch holds without load", alu_latch, 8'hC3);
    endtask

    task automatic t_swap();
        op_check("R3", 6'h01, 4'h3, 4'hC, 8'h3C);
        check("R3", "wb_en low after swap", {7'b0, wb_en}, 8'h00);
        @(negedge clk);
        alu_op = 6'h02; opnd_lo = 4'h7; opnd_hi = 4'h1; alu_load = 1'b1;
        #1;
        check("R3", "wb_en during swap-wb", {7'b0, wb_en}, 8'h01);
        check("R3", "wb_data during swap-wb", wb_data, 8'h71);
        @(negedge clk);
        alu_load = 1'b0;
        check("R3", "latch after swap-wb", alu_latch, 8'h71);
        #1;
        check("R3", "wb_en low without load", {7'b0, wb_en}, 8'h00);
    endtask

    task automatic t_bin_add();
        op_check("R4", 6'h03, 4'h7, 4'h5, 8'h0C);
        op_check("R4", 6'h03, 4'hF, 4'h1, 8'h10);
        set_carry(1'b1);
        op_check("R4", 6'h04, 4'h8, 4'h7, 8'h10);
        set_carry(1'b0);
        op_check("R4", 6'h04, 4'h8, 4'h7, 8'h0F);
    endtask

    task automatic t_bin_sub();
        op_check("R5", 6'h05, 4'h9, 4'h3, 8'h06);
        op_check("R5", 6'h05, 4'h3, 4'h5, 8'h1E);
        set_carry(1'b1);
        op_check("R5", 6'h06, 4'h5, 4'h5, 8'h1F);
        set_carry(1'b0);
        op_check("R5", 6'h06, 4'h5, 4'h5, 8'h00);
    endtask

    task automatic t_logic();
        op_check("R6", 6'h07, 4'hC, 4'hA, 8'h08);
        op_check("R6", 6'h08, 4'hC, 4'hA, 8'h0E);
        op_check("R6", 6'h09, 4'hC, 4'hA, 8'h06);
    endtask

    task automatic t_rotate();
        op_check("R7", 6'h0A, 4'h6, 4'h9, 8'h2D);
        op_check("R7", 6'h0B, 4'h6, 4'h9, 8'h4B);
        op_check("R7", 6'h0A, 4'h1, 4'h8, 8'h03);
    endtask

    task automatic t_step();
        op_check("R8", 6'h0C, 4'hF, 4'h0, 8'h10);
        op_check("R8", 6'h0C, 4'hF, 4'hF, 8'h00);
        op_check("R8", 6'h0D, 4'h0, 4'h1, 8'h0F);
        op_check("R8", 6'h0D, 4'h0, 4'h0, 8'hFF);
        op_check("R8", 6'h0E, 4'h5, 4'h2, 8'h36);
        op_check("R8", 6'h0E, 4'hF, 4'h2, 8'h30);
        op_check("R8", 6'h0F, 4'h0, 4'h2, 8'h1F);
        op_check("R8", 6'h0F, 4'h0, 4'h0, 8'hFF);
    endtask

    task automatic t_dec_add();
        op_check("R9", 6'h10, 4'h3, 4'h4, 8'h07);
        op_check("R9", 6'h10, 4'h5, 4'h5, 8'h10);
        op_check("R9", 6'h10, 4'h9, 4'h9, 8'h18);
        set_carry(1'b1);
        op_check("R9", 6'h11, 4'h4, 4'h5, 8'h10);
    endtask

    task automatic t_dec_sub();
        op_check("R10", 6'h12, 4'h8, 4'h3, 8'h05);
        op_check("R10", 6'h12, 4'h3, 4'h5, 8'h18);
        set_carry(1'b1);
        op_check("R10", 6'h13, 4'h0, 4'h0, 8'h19);
    endtask

    task automatic t_dec_step();
        op_check("R11", 6'h14, 4'h2, 4'h4, 8'h43);
        op_check("R11", 6'h14, 4'h9, 4'h1, 8'h20);
        op_check("R11", 6'h14, 4'h9, 4'h9, 8'h00);
        op_check("R11", 6'h15, 4'h0, 4'h2, 8'h19);
        op_check("R11", 6'h15, 4'h0, 4'h0, 8'h99);
    endtask

    task automatic t_compare();
        op_check("R12", 6'h16, 4'h5, 4'h5, 8'h10);
        op_check("R12", 6'h16, 4'h5, 4'h6, 8'h00);
        op_check("R12", 6'h17, 4'h7, 4'h3, 8'h10);
        op_check("R12", 6'h17, 4'h3, 4'h3, 8'h00);
        op_check("R12", 6'h18, 4'h3, 4'h3, 8'h10);
        op_check("R12", 6'h18, 4'h2, 4'h3, 8'h00);
    endtask

    task automatic t_carry_path();
        // Flag load and a new result in the same edge: carry takes the old latch bit 4.
        run_op(6'h03, 4'hF, 4'h1);
        @(negedge clk);
        alu_op = 6'h03; opnd_lo = 4'h1; opnd_hi = 4'h1; alu_load = 1'b1; flag_load = 1'b1;
        @(negedge clk);
        alu_load = 1'b0; flag_load = 1'b0;
        check("R13", "carry from old latch", {7'b0, carry_flag}, 8'h01);
        run_op(6'h00, 4'h0, 4'h0);
        check("R13", "carry holds without flag load", {7'b0, carry_flag}, 8'h01);
        // Carry-in on compare result chained into decimal add.
        run_op(6'h18, 4'h9, 4'h1);
        pulse_flag();
        op_check("R13", 6'h11, 4'h0, 4'h0, 8'h01);
    endtask

    task automatic t_unused();
        op_check("R14", 6'h19, 4'h5, 4'h5, 8'h00);
        op_check("R14", 6'h2A, 4'hF, 4'hF, 8'h00);
        op_check("R14", 6'h3F, 4'h9, 4'h9, 8'h00);
    endtask

    initial begin
        rst = 1'b1; alu_op = '0; opnd_lo = '0; opnd_hi = '0; alu_load = 1'b0; flag_load = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check("R1", "latch out of reset", alu_latch, 8'h00);
        check("R1", "carry out of reset", {7'b0, carry_flag}, 8'h00);
        t_pass_hold();
        t_swap();
        t_bin_add();
        t_bin_sub();
        t_logic();
        t_rotate();
        t_step();
        t_dec_add();
        t_dec_sub();
        t_dec_step();
        t_compare();
        t_carry_path();
        t_unused();
        t_reset();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end
endmodule